// File: doc/BRIEF.md
# Instruction Breakpoint Unit with Overrun Filtering

This block watches the instruction-fetch stream and the data-access stream of a processor core. It raises a one-cycle break request when an address matches a programmed break address, with a mask that marks address bits as don't-care. A kind field selects whether instruction fetches, data accesses, both or neither can match. Instruction fetches arrive one or two per cycle. Each fetch is compared against the break condition in the cycle it arrives. The result waits in a small in-flight queue together with the fetch address and a sequence tag.

An instruction break is reported only when the core confirms that the oldest queued fetch executed. Fetches fetched past a taken branch or trap are cut from the queue by a squash that names the last surviving tag, so they never cause an instruction break. A delay-slot instruction is confirmed before the squash, so it can still break. Data accesses are not filtered. A matching data access breaks in the next cycle even if it was issued on behalf of an instruction that is later squashed.

Each break also sets one of two sticky cause bits, one for instruction and one for data. Any write of the break condition clears both bits.

Top module: `ibrk_unit`

## Requirements
- R1: After reset, brk_req, stat_ibrk and stat_dbrk are 0, the queue is empty, the break kind is disabled, and the next accepted fetch gets tag 0.
- R2: An address matches when ((addr XOR cfg_addr) AND NOT cfg_mask) is zero; a mask bit of 1 makes that bit don't-care. The kind field selects which streams can match: 2'b00 disables all breaks, 2'b01 allows instruction fetches only, 2'b10 allows data accesses only, and 2'b11 allows both.
- R3: Both fetch lanes are compared independently. Lane 0 is older than lane 1. Accepted fetches take consecutive tags, modulo 2^TW, in arrival order. Lane 1 is ignored unless lane 0 is valid in the same cycle.
- R4: Each fetch's match is decided with the condition held in the cycle of the fetch. A condition write in the same cycle as a fetch, or in any later cycle, does not change that fetch's outcome.
- R5: ex_vld confirms the oldest queued entry. If that entry matched, brk_req is 1 in the next cycle, with brk_data 0, brk_tag set to the entry's tag and brk_addr set to its address. ex_vld on an empty queue does nothing.
- R6: sq_vld removes every queued entry younger than sq_tag. If ex_vld is high in the same cycle, the confirm is applied first. Fetches accepted in the same cycle as the squash are appended after the cut and take the tags that follow sq_tag. Removed entries never break. A squash is ignored when sq_tag+1 lies outside the range from the oldest remaining tag to the next free tag.
- R7: A matching d_vld access gives brk_req with brk_data 1 and brk_addr set to d_addr in the next cycle. This holds whatever the state of the queue and any squash.
- R8: When an instruction break and a data break occur in the same cycle, the output reports the instruction break, and both sticky bits are set.
- R9: stat_ibrk and stat_dbrk are set with their break and stay set until a condition write. A break in the same cycle as a write still sets its bit.
- R10: The queue holds DEPTH entries. Free room is counted after the same cycle's confirm and squash. A fetch that does not fit is dropped, lane 0 being placed before lane 1, and a dropped fetch takes no tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Write break condition, clears sticky bits |
| cfg_addr | input | AW | Break address |
| cfg_mask | input | AW | Don't-care bits of the address |
| cfg_kind | input | 2 | Break kind: 00 off, 01 fetch, 10 data, 11 both |
| f0_vld | input | 1 | Older fetch lane valid |
| f0_addr | input | AW | Older fetch lane address |
| f1_vld | input | 1 | Younger fetch lane valid |
| f1_addr | input | AW | Younger fetch lane address |
| ex_vld | input | 1 | Oldest queued fetch executed |
| sq_vld | input | 1 | Squash entries younger than sq_tag |
| sq_tag | input | TW | Last surviving tag of a squash |
| d_vld | input | 1 | Data access valid |
| d_addr | input | AW | Data access address |
| brk_req | output | 1 | Break request pulse |
| brk_data | output | 1 | Break was caused by a data access |
| brk_tag | output | TW | Tag of the breaking instruction |
| brk_addr | output | AW | Address that caused the break |
| stat_ibrk | output | 1 | Sticky: instruction break seen |
| stat_dbrk | output | 1 | Sticky: data break seen |

## Verification
The compare logic is swept over every address of an 8-bit configuration. Fetch pairs are confirmed one at a time, which separates lane ordering and tag numbering from mask handling. A sweep over all data addresses does the same for the data path. All four kind codes are tried on both streams. Three squash patterns are run: a plain branch or trap, a delayed branch with its slot confirmed first, and an out-of-range tag. These separate cutting the queue from confirming it. A data match issued by an overrun fetch shows that the data path ignores squashes. Full-queue fetches, including a pop and a push in the same cycle and a lane-1-only fetch, show how free room is counted.

// File: rtl/ibrk_pkg.sv
`timescale 1ns/1ps
package ibrk_pkg;
    typedef enum logic [1:0] {
        BRK_OFF   = 2'b00,
        BRK_FETCH = 2'b01,
        BRK_DATA  = 2'b10,
        BRK_BOTH  = 2'b11
    } brk_kind_e;

    localparam int N_LANES = 3;
    localparam int LANE_F0 = 0;
    localparam int LANE_F1 = 1;
    localparam int LANE_D  = 2;
endpackage

// File: rtl/ibrk_cond.sv
`timescale 1ns/1ps
module ibrk_cond import ibrk_pkg::*; #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [AW-1:0] cfg_mask,
    input  logic [1:0]    cfg_kind,
    input  logic          f0_vld,
    input  logic [AW-1:0] f0_addr,
    input  logic          f1_vld,
    input  logic [AW-1:0] f1_addr,
    input  logic          d_vld,
    input  logic [AW-1:0] d_addr,
    output logic          f0_hit,
    output logic          f1_hit,
    output logic          d_hit
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] mask;
        brk_kind_e     kind;
    } cond_t;

    cond_t cond_d, cond_q;

    always_comb begin
        cond_d = cond_q;
        if (cfg_we) begin
            cond_d.addr = cfg_addr;
            cond_d.mask = cfg_mask;
            cond_d.kind = brk_kind_e'(cfg_kind);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= '{addr: '0, mask: '0, kind: BRK_OFF};
        end else begin
            cond_q <= cond_d;
        end
    end

    // One comparator per lane; every lane sees the condition currently held.
    logic [AW-1:0]      lane_addr [N_LANES];
    logic [N_LANES-1:0] lane_eq;
    logic [1:0]         kind_bits;

    assign lane_addr[LANE_F0] = f0_addr;
    assign lane_addr[LANE_F1] = f1_addr;
    assign lane_addr[LANE_D]  = d_addr;
    assign kind_bits          = cond_q.kind;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        assign lane_eq[g] = ((lane_addr[g] ^ cond_q.addr) & ~cond_q.mask) == '0;
    end

    assign f0_hit = f0_vld & kind_bits[0] & lane_eq[LANE_F0];
    assign f1_hit = f1_vld & kind_bits[0] & lane_eq[LANE_F1];
    assign d_hit  = d_vld  & kind_bits[1] & lane_eq[LANE_D];

    // R2: kind 00 never lets a lane match in the following cycle either
    assert_off_blocks_hits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_kind == 2'b00) |=> !(f0_hit || f1_hit || d_hit));
endmodule

// File: rtl/ibrk_fifo.sv
`timescale 1ns/1ps
module ibrk_fifo #(
    parameter int AW    = 32,
    parameter int DEPTH = 4,
    localparam int IW   = $clog2(DEPTH),
    localparam int TW   = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push0,
    input  logic          push1,
    input  logic [AW-1:0] addr0,
    input  logic [AW-1:0] addr1,
    input  logic          hit0,
    input  logic          hit1,
    input  logic          pop_req,
    input  logic          sq_vld,
    input  logic [TW-1:0] sq_tag,
    output logic          pop_fire,
    output logic          pop_hit,
    output logic [TW-1:0] pop_tag,
    output logic [AW-1:0] pop_addr
);
    typedef struct packed {
        logic [TW-1:0]             rptr;
        logic [TW-1:0]             wptr;
        logic [DEPTH-1:0]          hit;
        logic [DEPTH-1:0][AW-1:0]  addr;
    } fifo_t;

    fifo_t fq_d, fq_q;

    logic [TW-1:0] cnt, rp1, wp1, cut, span_now, span_cut, used;
    logic [TW:0]   free;
    logic          pop, sq_ok, acc0, acc1;
    logic [IW-1:0] idx0, idx1;

    always_comb begin
        fq_d     = fq_q;
        cnt      = fq_q.wptr - fq_q.rptr;
        pop      = pop_req && (cnt != '0);
        rp1      = fq_q.rptr + TW'(pop);
        // Squash cut is legal only within [rp1, wptr].
        cut      = sq_tag + TW'(1);
        span_now = fq_q.wptr - rp1;
        span_cut = cut - rp1;
        sq_ok    = sq_vld && (span_cut <= span_now);
        wp1      = sq_ok ? cut : fq_q.wptr;
        used     = wp1 - rp1;
        free     = (TW+1)'(DEPTH) - {1'b0, used};
        acc0     = push0 && (free >= (TW+1)'(1));
        acc1     = push0 && push1 && (free >= (TW+1)'(2));
        idx0     = wp1[IW-1:0];
        idx1     = idx0 + IW'(1);
        if (acc0) begin
            fq_d.hit[idx0]  = hit0;
            fq_d.addr[idx0] = addr0;
        end
        if (acc1) begin
            fq_d.hit[idx1]  = hit1;
            fq_d.addr[idx1] = addr1;
        end
        fq_d.rptr = rp1;
        fq_d.wptr = wp1 + TW'(acc0) + TW'(acc1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fq_q <= '0;
        end else begin
            fq_q <= fq_d;
        end
    end

    assign pop_fire = pop;
    assign pop_hit  = fq_q.hit[fq_q.rptr[IW-1:0]];
    assign pop_tag  = fq_q.rptr;
    assign pop_addr = fq_q.addr[fq_q.rptr[IW-1:0]];

    // R10: occupancy never exceeds the queue depth
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, cnt} <= (TW+1)'(DEPTH));

    // R6: a squash with no new fetch never grows the queue
    assert_squash_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_vld && !push0) |=> (fq_q.wptr - fq_q.rptr) <= $past(cnt));
endmodule

// File: rtl/ibrk_report.sv
`timescale 1ns/1ps
module ibrk_report #(
    parameter int AW = 32,
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          i_evt,
    input  logic [TW-1:0] i_tag,
    input  logic [AW-1:0] i_addr,
    input  logic          d_evt,
    input  logic [AW-1:0] d_addr,
    output logic          brk_req,
    output logic          brk_data,
    output logic [TW-1:0] brk_tag,
    output logic [AW-1:0] brk_addr,
    output logic          stat_i,
    output logic          stat_d
);
    typedef struct packed {
        logic          req;
        logic          data;
        logic [TW-1:0] tag;
        logic [AW-1:0] addr;
        logic          st_i;
        logic          st_d;
    } rep_t;

    rep_t rp_d, rp_q;

    always_comb begin
        rp_d      = rp_q;
        rp_d.req  = i_evt | d_evt;
        rp_d.data = d_evt & ~i_evt;
        rp_d.tag  = i_evt ? i_tag : '0;
        rp_d.addr = i_evt ? i_addr : (d_evt ? d_addr : '0);
        rp_d.st_i = (clr ? 1'b0 : rp_q.st_i) | i_evt;
        rp_d.st_d = (clr ? 1'b0 : rp_q.st_d) | d_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp_q <= '0;
        end else begin
            rp_q <= rp_d;
        end
    end

    assign brk_req  = rp_q.req;
    assign brk_data = rp_q.data;
    assign brk_tag  = rp_q.tag;
    assign brk_addr = rp_q.addr;
    assign stat_i   = rp_q.st_i;
    assign stat_d   = rp_q.st_d;

    // R9: the instruction sticky bit only rises with an instruction break
    assert_sticky_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_i) |-> (brk_req && !brk_data));

    // R9: a data break is always recorded in its sticky bit
    assert_data_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && brk_data) |-> stat_d);
endmodule

// File: rtl/ibrk_unit.sv
`timescale 1ns/1ps
module ibrk_unit #(
    parameter int AW    = 32,
    parameter int DEPTH = 4,
    localparam int TW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [AW-1:0] cfg_mask,
    input  logic [1:0]    cfg_kind,
    input  logic          f0_vld,
    input  logic [AW-1:0] f0_addr,
    input  logic          f1_vld,
    input  logic [AW-1:0] f1_addr,
    input  logic          ex_vld,
    input  logic          sq_vld,
    input  logic [TW-1:0] sq_tag,
    input  logic          d_vld,
    input  logic [AW-1:0] d_addr,
    output logic          brk_req,
    output logic          brk_data,
    output logic [TW-1:0] brk_tag,
    output logic [AW-1:0] brk_addr,
    output logic          stat_ibrk,
    output logic          stat_dbrk
);
    logic          f0_hit, f1_hit, d_hit;
    logic          pop_fire, pop_hit;
    logic [TW-1:0] pop_tag;
    logic [AW-1:0] pop_addr;
    logic          i_evt;

    ibrk_cond #(.AW(AW)) u_cond (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_mask(cfg_mask), .cfg_kind(cfg_kind),
        .f0_vld(f0_vld), .f0_addr(f0_addr), .f1_vld(f1_vld), .f1_addr(f1_addr),
        .d_vld(d_vld), .d_addr(d_addr),
        .f0_hit(f0_hit), .f1_hit(f1_hit), .d_hit(d_hit)
    );

    ibrk_fifo #(.AW(AW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push0(f0_vld), .push1(f1_vld),
        .addr0(f0_addr), .addr1(f1_addr),
        .hit0(f0_hit), .hit1(f1_hit),
        .pop_req(ex_vld), .sq_vld(sq_vld), .sq_tag(sq_tag),
        .pop_fire(pop_fire), .pop_hit(pop_hit), .pop_tag(pop_tag), .pop_addr(pop_addr)
    );

    assign i_evt = pop_fire & pop_hit;

    ibrk_report #(.AW(AW), .TW(TW)) u_report (
        .clk(clk), .rst_n(rst_n), .clr(cfg_we),
        .i_evt(i_evt), .i_tag(pop_tag), .i_addr(pop_addr),
        .d_evt(d_hit), .d_addr(d_addr),
        .brk_req(brk_req), .brk_data(brk_data), .brk_tag(brk_tag), .brk_addr(brk_addr),
        .stat_i(stat_ibrk), .stat_d(stat_dbrk)
    );

    // R5: an instruction break always follows an execute confirm
    assert_ibrk_needs_confirm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && !brk_data) |-> $past(ex_vld));

    // R7: a data break always follows a data access
    assert_dbrk_needs_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && brk_data) |-> $past(d_vld));
endmodule

// File: tb/ibrk_unit_bench.sv
`timescale 1ns/1ps
module ibrk_unit_bench;
    localparam int AW = 8;
    localparam int DEPTH = 4;
    localparam int TW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          cfg_we = 0, f0_vld = 0, f1_vld = 0, ex_vld = 0, sq_vld = 0, d_vld = 0;
    logic [AW-1:0] cfg_addr = 0, cfg_mask = 0, f0_addr = 0, f1_addr = 0, d_addr = 0;
    logic [1:0]    cfg_kind = 0;
    logic [TW-1:0] sq_tag = 0;
    logic          brk_req, brk_data, stat_ibrk, stat_dbrk;
    logic [TW-1:0] brk_tag;
    logic [AW-1:0] brk_addr;

    ibrk_unit #(.AW(AW), .DEPTH(DEPTH)) u_ibrk_unit (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_mask(cfg_mask), .cfg_kind(cfg_kind),
        .f0_vld(f0_vld), .f0_addr(f0_addr), .f1_vld(f1_vld), .f1_addr(f1_addr),
        .ex_vld(ex_vld), .sq_vld(sq_vld), .sq_tag(sq_tag),
        .d_vld(d_vld), .d_addr(d_addr),
        .brk_req(brk_req), .brk_data(brk_data), .brk_tag(brk_tag), .brk_addr(brk_addr),
        .stat_ibrk(stat_ibrk), .stat_dbrk(stat_dbrk)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [TW-1:0] ntag = 0;
    logic [TW-1:0] t0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic bit hit8(input logic [7:0] a, input logic [7:0] c, input logic [7:0] m);
        return ((a ^ c) & ~m) == 8'h00;
    endfunction

    task automatic cfg(input logic [7:0] a, input logic [7:0] m, input logic [1:0] k);
        cfg_we = 1; cfg_addr = a; cfg_mask = m; cfg_kind = k;
        cyc();
        cfg_we = 0;
    endtask

    task automatic fetch(input logic v0, input logic [7:0] a0, input logic v1, input logic [7:0] a1);
        f0_vld = v0; f0_addr = a0; f1_vld = v1; f1_addr = a1;
        cyc();
        f0_vld = 0; f1_vld = 0;
    endtask

    task automatic confirm(input string req, input bit eb, input logic [TW-1:0] et, input logic [7:0] ea);
        ex_vld = 1;
        cyc();
        ex_vld = 0;
        chk(req, 32'(brk_req), 32'(eb));
        if (eb) begin
            chk(req, 32'(brk_data), 32'(0));
            chk(req, 32'(brk_tag), 32'(et));
            chk(req, 32'(brk_addr), 32'(ea));
        end
    endtask

    task automatic data(input string req, input logic [7:0] a, input bit eb);
        d_vld = 1; d_addr = a;
        cyc();
        d_vld = 0;
        chk(req, 32'(brk_req), 32'(eb));
        if (eb) begin
            chk(req, 32'(brk_data), 32'(1));
            chk(req, 32'(brk_addr), 32'(a));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset brk_req", 32'(brk_req), 32'(0));
        rst_n = 1;
        cyc();
        chk("R1 stat_ibrk", 32'(stat_ibrk), 32'(0));
        chk("R1 stat_dbrk", 32'(stat_dbrk), 32'(0));
        confirm("R1 empty queue", 0, 0, 0);
        data("R1 kind off", 8'h00, 0);

        // R2 R3 R5: pair sweep over every address
        cfg(8'h5A, 8'h03, 2'b01);
        for (int i = 0; i < 128; i++) begin
            fetch(1, 8'(2*i), 1, 8'(2*i+1));
            confirm("R3 lane0", hit8(8'(2*i), 8'h5A, 8'h03), ntag, 8'(2*i));
            ntag = ntag + 1;
            confirm("R3 lane1", hit8(8'(2*i+1), 8'h5A, 8'h03), ntag, 8'(2*i+1));
            ntag = ntag + 1;
        end

        // R2: every kind code on both streams
        for (int k = 0; k < 4; k++) begin
            cfg(8'h33, 8'h00, 2'(k));
            fetch(1, 8'h33, 0, 8'h00);
            confirm("R2 fetch kind", k[0], ntag, 8'h33);
            ntag = ntag + 1;
            data("R2 data kind", 8'h33, k[1]);
        end

        // R7: data sweep
        cfg(8'hC0, 8'h0F, 2'b10);
        for (int a = 0; a < 256; a++) begin
            data("R7 data sweep", 8'(a), hit8(8'(a), 8'hC0, 8'h0F));
        end

        // R4: condition rewritten after fetch
        cfg(8'h10, 8'h00, 2'b01);
        fetch(1, 8'h10, 1, 8'h20);
        cfg(8'h20, 8'h00, 2'b01);
        confirm("R4 old cond lane0", 1, ntag, 8'h10);
        ntag = ntag + 1;
        confirm("R4 old cond lane1", 0, ntag, 8'h20);
        ntag = ntag + 1;
        // R4: write in the same cycle as the pair
        cfg_we = 1; cfg_addr = 8'h10; cfg_mask = 0; cfg_kind = 2'b01;
        f0_vld = 1; f0_addr = 8'h10; f1_vld = 1; f1_addr = 8'h20;
        cyc();
        cfg_we = 0; f0_vld = 0; f1_vld = 0;
        confirm("R4 same-cycle lane0", 0, ntag, 8'h10);
        ntag = ntag + 1;
        confirm("R4 same-cycle lane1", 1, ntag, 8'h20);
        ntag = ntag + 1;

        // R6: plain branch or trap, two overrun fetches cut
        cfg(8'h00, 8'hFF, 2'b01);
        t0 = ntag;
        fetch(1, 8'h40, 1, 8'h41);
        fetch(1, 8'h42, 0, 8'h00);
        confirm("R6 branch", 1, t0, 8'h40);
        sq_vld = 1; sq_tag = t0; f0_vld = 1; f0_addr = 8'h80;
        cyc();
        sq_vld = 0; f0_vld = 0;
        confirm("R6 target after squash", 1, t0 + 3'd1, 8'h80);
        confirm("R6 overruns gone", 0, 0, 0);
        ntag = t0 + 3'd2;

        // R6: delayed branch, slot confirmed before the cut
        t0 = ntag;
        fetch(1, 8'h50, 1, 8'h51);
        fetch(1, 8'h52, 0, 8'h00);
        confirm("R6 delayed branch", 1, t0, 8'h50);
        confirm("R6 delay slot", 1, t0 + 3'd1, 8'h51);
        sq_vld = 1; sq_tag = t0 + 3'd1; f0_vld = 1; f0_addr = 8'h90;
        cyc();
        sq_vld = 0; f0_vld = 0;
        confirm("R6 delayed target", 1, t0 + 3'd2, 8'h90);
        confirm("R6 delayed overrun gone", 0, 0, 0);
        ntag = t0 + 3'd3;

        // R6: out-of-range squash ignored
        t0 = ntag;
        fetch(1, 8'h60, 0, 8'h00);
        sq_vld = 1; sq_tag = t0 + 3'd3;
        cyc();
        sq_vld = 0;
        confirm("R6 bad squash ignored", 1, t0, 8'h60);
        ntag = t0 + 3'd1;

        // R7: data access of a squashed overrun still breaks
        cfg(8'h70, 8'h00, 2'b11);
        t0 = ntag;
        fetch(1, 8'h6F, 1, 8'h70);
        data("R7 overrun data", 8'h70, 1);
        confirm("R7 branch no match", 0, t0, 8'h6F);
        sq_vld = 1; sq_tag = t0;
        cyc();
        sq_vld = 0;
        chk("R6 squash no break", 32'(brk_req), 32'(0));
        confirm("R6 matching overrun dropped", 0, 0, 0);
        ntag = t0 + 3'd1;

        // R8: simultaneous instruction and data breaks
        cfg(8'h00, 8'hFF, 2'b11);
        fetch(1, 8'h11, 0, 8'h00);
        ex_vld = 1; d_vld = 1; d_addr = 8'h22;
        cyc();
        ex_vld = 0; d_vld = 0;
        chk("R8 req", 32'(brk_req), 32'(1));
        chk("R8 instr wins", 32'(brk_data), 32'(0));
        chk("R8 tag", 32'(brk_tag), 32'(ntag));
        chk("R8 addr", 32'(brk_addr), 32'(8'h11));
        chk("R8 stat_ibrk", 32'(stat_ibrk), 32'(1));
        chk("R8 stat_dbrk", 32'(stat_dbrk), 32'(1));
        ntag = ntag + 1;

        // R9: sticky, cleared by write, set wins
        cyc();
        chk("R9 sticky i", 32'(stat_ibrk), 32'(1));
        chk("R9 sticky d", 32'(stat_dbrk), 32'(1));
        cfg(8'h00, 8'hFF, 2'b11);
        chk("R9 clear i", 32'(stat_ibrk), 32'(0));
        chk("R9 clear d", 32'(stat_dbrk), 32'(0));
        fetch(1, 8'h12, 0, 8'h00);
        ex_vld = 1; cfg_we = 1;
        cyc();
        ex_vld = 0; cfg_we = 0;
        chk("R9 set wins", 32'(stat_ibrk), 32'(1));
        chk("R9 set wins d", 32'(stat_dbrk), 32'(0));
        ntag = ntag + 1;

        // R10: capacity and drops
        cfg(8'h00, 8'hFF, 2'b01);
        t0 = ntag;
        fetch(1, 8'hA0, 1, 8'hA1);
        fetch(1, 8'hA2, 0, 8'h00);
        fetch(1, 8'hA3, 1, 8'hA4);
        fetch(1, 8'hA5, 1, 8'hA6);
        for (int j = 0; j < 4; j++) begin
            confirm("R10 kept", 1, t0 + 3'(j), 8'hA0 + 8'(j));
        end
        confirm("R10 dropped", 0, 0, 0);
        ntag = t0 + 3'd4;
        fetch(0, 8'h00, 1, 8'hB0);
        confirm("R3 lane1 alone ignored", 0, 0, 0);

        // R10: pop frees room in the same cycle
        t0 = ntag;
        fetch(1, 8'hC0, 1, 8'hC1);
        fetch(1, 8'hC2, 1, 8'hC3);
        ex_vld = 1; f0_vld = 1; f0_addr = 8'hC4; f1_vld = 1; f1_addr = 8'hC5;
        cyc();
        ex_vld = 0; f0_vld = 0; f1_vld = 0;
        chk("R10 pop+push req", 32'(brk_req), 32'(1));
        chk("R10 pop+push tag", 32'(brk_tag), 32'(t0));
        for (int j = 1; j < 5; j++) begin
            confirm("R10 after pop+push", 1, t0 + 3'(j), 8'hC0 + 8'(j));
        end
        confirm("R10 lane1 dropped", 0, 0, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule